// File: doc/BRIEF.md
# Address Register Unit

This block keeps the wide pointer registers of a small 8-bit processor core: a program counter, a stack pointer, a link pointer, a source pointer, a destination pointer and a transfer register, all 16 bits. It also keeps a 16-bit constant register. A single 16-bit address bus links them. A 3-bit write code picks the register that captures the bus. A 3-bit read code picks the register whose value goes out on the bus.

The narrow 8-bit main bus reaches the wide side through two registers. The transfer register takes either of its bytes from the main bus, and it can also be loaded whole from the address bus. The constant register takes its two bytes from the main bus, can be read onto the address bus, and can return its low byte to the main bus.

Five of the pointers step by one whenever their active-low count enable is asserted. Three of them also have an up/down line. The control sequencer drives every control line in every cycle. All outputs are registered.

Top module: `addr_reg_unit`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. It also drives abus_out, mbus_out, abus_valid, mbus_valid and tx_conflict low.
- R2: At a clock edge, wr_sel loads abus_in into one register: 2 selects the destination pointer, 3 the source pointer, 4 the link pointer, 5 the stack pointer, 6 the program counter and 7 the transfer register. Codes 0 and 1 load nothing.
- R3: The read code uses the same numbering as the write code, with 1 selecting the constant register. For any nonzero rd_sel, abus_out shows the selected register one cycle later, with abus_valid high. The value shown is the content before any update at that same edge.
- R4: With rd_sel equal to 0, abus_out is zero and abus_valid is low in the following cycle.
- R5: Count enables are active low. While one is asserted, its register changes by one per cycle and wraps modulo 65536. The program counter and the link pointer always count upward.
- R6: The stack, source and destination pointers count up when their direction line is 1 and down when it is 0.
- R7: If a register is selected by wr_sel while its count enable is asserted, it takes abus_in and does not count.
- R8: tx_hi_ld loads mbus_in into bits 15:8 of the transfer register, and tx_lo_ld loads it into bits 7:0. The two loads act independently and may occur in the same cycle.
- R9: If tx_hi_ld or tx_lo_ld is high while wr_sel is 7, tx_conflict is high in the next cycle and the 16-bit load from abus_in wins. Otherwise tx_conflict is low.
- R10: k_hi_ld loads mbus_in into bits 15:8 of the constant register, and k_lo_ld loads it into bits 7:0.
- R11: With k_drive high, mbus_out carries the constant register's low byte in the next cycle, with mbus_valid high. With k_drive low, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_sel | input | 3 | Write code for the 16-bit load |
| rd_sel | input | 3 | Read code for the address bus output |
| abus_in | input | 16 | Address bus data to load |
| abus_out | output | 16 | Registered address bus output |
| abus_valid | output | 1 | abus_out carries a register |
| mbus_in | input | 8 | Main bus byte for byte loads |
| mbus_out | output | 8 | Registered constant low byte |
| mbus_valid | output | 1 | mbus_out is being driven |
| tx_hi_ld | input | 1 | Load transfer high byte |
| tx_lo_ld | input | 1 | Load transfer low byte |
| k_hi_ld | input | 1 | Load constant high byte |
| k_lo_ld | input | 1 | Load constant low byte |
| k_drive | input | 1 | Put constant low byte on the main bus |
| pc_cnt_n | input | 1 | Program counter count enable, active low |
| li_cnt_n | input | 1 | Link pointer count enable, active low |
| sp_cnt_n | input | 1 | Stack pointer count enable, active low |
| sp_up | input | 1 | Stack pointer direction, 1 = up |
| si_cnt_n | input | 1 | Source pointer count enable, active low |
| si_up | input | 1 | Source pointer direction, 1 = up |
| di_cnt_n | input | 1 | Destination pointer count enable, active low |
| di_up | input | 1 | Destination pointer direction, 1 = up |
| tx_conflict | output | 1 | A byte load collided with a full transfer load |

## Verification
The registers can only be seen through the read path. A wrong count step, a wrong direction or a missed load therefore shows at abus_out only when the affected register is next selected, and then one cycle after the read code is applied. The bench models every register and compares all five outputs after every edge. Because rd_sel is drawn at random, corrupted state turns up within a few cycles of its cause. Directed cases cover wraparound at both ends, a load and a count in the same cycle, and a byte load that collides with a full transfer load.

// File: rtl/addr_unit_pkg.sv
package addr_unit_pkg;
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CONST = 3'd1,
    SEL_DI    = 3'd2,
    SEL_SI    = 3'd3,
    SEL_LI    = 3'd4,
    SEL_SP    = 3'd5,
    SEL_PC    = 3'd6,
    SEL_TX    = 3'd7
  } sel_e;

  // Counting pointers, index i answers to select code i+2
  localparam int NUM_CNT  = 5;
  localparam int CNT_BASE = 2;
  // Bit set where the pointer owns a direction line (di, si, sp)
  localparam logic [NUM_CNT-1:0] DIR_MASK = 5'b01011;
endpackage

// File: rtl/addr_count_reg.sv
module addr_count_reg #(
  parameter int W       = 16,
  parameter bit HAS_DIR = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         cnt_n,
  input  logic         up,
  output logic [W-1:0] q
);
  logic [W-1:0] step;

  generate
    if (HAS_DIR) begin : g_dir
      assign step = up ? W'(1) : {W{1'b1}};
    end else begin : g_fixed
      logic unused_up;
      assign unused_up = up;
      assign step      = W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (ld)     q <= ld_val;
    else if (!cnt_n) q <= q + step;
  end

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(ld_val));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!ld && cnt_n) |=> $stable(q));

  generate
    if (HAS_DIR) begin : g_chk_dir
      assert_count_up_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld && !cnt_n && up) |=> q == $past(q) + W'(1));
      assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld && !cnt_n && !up) |=> q == $past(q) - W'(1));
    end else begin : g_chk_up
      assert_count_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!ld && !cnt_n) |=> q == $past(q) + W'(1));
    end
  endgenerate
endmodule

// File: rtl/addr_xfer_reg.sv
module addr_xfer_reg #(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [W-1:0]  ld_val,
  input  logic          hi_ld,
  input  logic          lo_ld,
  input  logic [BW-1:0] byte_in,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ld) begin
      q <= ld_val;
    end else begin
      if (hi_ld) q[W-1:BW] <= byte_in;
      if (lo_ld) q[BW-1:0] <= byte_in;
    end
  end

  assert_hi_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (!ld && hi_ld) |=> q[W-1:BW] == $past(byte_in));
  assert_lo_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (!ld && lo_ld) |=> q[BW-1:0] == $past(byte_in));
  assert_full_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(ld_val));
endmodule

// File: rtl/addr_const_reg.sv
module addr_const_reg #(
  parameter int BW = 8,
  localparam int W = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hi_ld,
  input  logic          lo_ld,
  input  logic [BW-1:0] byte_in,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (hi_ld) q[W-1:BW] <= byte_in;
      if (lo_ld) q[BW-1:0] <= byte_in;
    end
  end

  assert_const_lo_R10: assert property (@(posedge clk) disable iff (rst)
    lo_ld |=> q[BW-1:0] == $past(byte_in));
  assert_const_hi_R10: assert property (@(posedge clk) disable iff (rst)
    hi_ld |=> q[W-1:BW] == $past(byte_in));
endmodule

// File: rtl/addr_reg_unit.sv
module addr_reg_unit
  import addr_unit_pkg::*;
#(
  parameter int BW = 8,
  localparam int AW = 2 * BW,
  localparam int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] wr_sel,
  input  logic [SW-1:0] rd_sel,
  input  logic [AW-1:0] abus_in,
  output logic [AW-1:0] abus_out,
  output logic          abus_valid,
  input  logic [BW-1:0] mbus_in,
  output logic [BW-1:0] mbus_out,
  output logic          mbus_valid,
  input  logic          tx_hi_ld,
  input  logic          tx_lo_ld,
  input  logic          k_hi_ld,
  input  logic          k_lo_ld,
  input  logic          k_drive,
  input  logic          pc_cnt_n,
  input  logic          li_cnt_n,
  input  logic          sp_cnt_n,
  input  logic          sp_up,
  input  logic          si_cnt_n,
  input  logic          si_up,
  input  logic          di_cnt_n,
  input  logic          di_up,
  output logic          tx_conflict
);
  logic [NUM_CNT-1:0] cnt_ld;
  logic [NUM_CNT-1:0] cnt_en_n;
  logic [NUM_CNT-1:0] cnt_up;
  logic [AW-1:0]      cnt_q [NUM_CNT];
  logic [AW-1:0]      tx_q;
  logic [AW-1:0]      k_q;
  logic [AW-1:0]      rd_mux;
  logic               tx_ld;
  logic               clash;

  // index order: di, si, li, sp, pc
  assign cnt_en_n = {pc_cnt_n, sp_cnt_n, li_cnt_n, si_cnt_n, di_cnt_n};
  assign cnt_up   = {1'b1, sp_up, 1'b1, si_up, di_up};

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      assign cnt_ld[i] = (wr_sel == SW'(i + CNT_BASE));
      addr_count_reg #(
        .W       (AW),
        .HAS_DIR (DIR_MASK[i])
      ) i_cnt (
        .clk    (clk),
        .rst    (rst),
        .ld     (cnt_ld[i]),
        .ld_val (abus_in),
        .cnt_n  (cnt_en_n[i]),
        .up     (cnt_up[i]),
        .q      (cnt_q[i])
      );
    end
  endgenerate

  assign tx_ld = (wr_sel == SEL_TX);
  assign clash = tx_ld && (tx_hi_ld || tx_lo_ld);

  addr_xfer_reg #(.BW(BW)) i_xfer (
    .clk     (clk),
    .rst     (rst),
    .ld      (tx_ld),
    .ld_val  (abus_in),
    .hi_ld   (tx_hi_ld),
    .lo_ld   (tx_lo_ld),
    .byte_in (mbus_in),
    .q       (tx_q)
  );

  addr_const_reg #(.BW(BW)) i_const (
    .clk     (clk),
    .rst     (rst),
    .hi_ld   (k_hi_ld),
    .lo_ld   (k_lo_ld),
    .byte_in (mbus_in),
    .q       (k_q)
  );

  always_comb begin
    case (sel_e'(rd_sel))
      SEL_CONST: rd_mux = k_q;
      SEL_DI:    rd_mux = cnt_q[0];
      SEL_SI:    rd_mux = cnt_q[1];
      SEL_LI:    rd_mux = cnt_q[2];
      SEL_SP:    rd_mux = cnt_q[3];
      SEL_PC:    rd_mux = cnt_q[4];
      SEL_TX:    rd_mux = tx_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      abus_out    <= '0;
      abus_valid  <= 1'b0;
      mbus_out    <= '0;
      mbus_valid  <= 1'b0;
      tx_conflict <= 1'b0;
    end else begin
      abus_out    <= rd_mux;
      abus_valid  <= (rd_sel != SEL_NONE);
      mbus_out    <= k_drive ? k_q[BW-1:0] : '0;
      mbus_valid  <= k_drive;
      tx_conflict <= clash;
    end
  end

  assert_idle_bus_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_NONE) |=> (abus_out == '0 && !abus_valid));
  assert_read_pc_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_PC) |=> (abus_valid && abus_out == $past(cnt_q[4])));
  assert_clash_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ((tx_hi_ld || tx_lo_ld) && wr_sel == SEL_TX) |=> tx_conflict);
  assert_mbus_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !k_drive |=> (mbus_out == '0 && !mbus_valid));
endmodule

// File: tb/test_addr_reg_unit.sv
module test_addr_reg_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  wr_sel, rd_sel;
  logic [15:0] abus_in, abus_out;
  logic        abus_valid;
  logic [7:0]  mbus_in, mbus_out;
  logic        mbus_valid;
  logic        tx_hi_ld, tx_lo_ld, k_hi_ld, k_lo_ld, k_drive;
  logic        pc_cnt_n, li_cnt_n, sp_cnt_n, sp_up;
  logic        si_cnt_n, si_up, di_cnt_n, di_up;
  logic        tx_conflict;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] m [8];   // model: index = select code, 1 = constant

  always #2 clk = ~clk;

  addr_reg_unit i_addr_reg_unit (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .rd_sel(rd_sel),
    .abus_in(abus_in), .abus_out(abus_out), .abus_valid(abus_valid),
    .mbus_in(mbus_in), .mbus_out(mbus_out), .mbus_valid(mbus_valid),
    .tx_hi_ld(tx_hi_ld), .tx_lo_ld(tx_lo_ld), .k_hi_ld(k_hi_ld),
    .k_lo_ld(k_lo_ld), .k_drive(k_drive), .pc_cnt_n(pc_cnt_n),
    .li_cnt_n(li_cnt_n), .sp_cnt_n(sp_cnt_n), .sp_up(sp_up),
    .si_cnt_n(si_cnt_n), .si_up(si_up), .di_cnt_n(di_cnt_n),
    .di_up(di_up), .tx_conflict(tx_conflict)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] f_count(logic [15:0] v, logic en_n, logic up);
    if (en_n) return v;
    return up ? v + 16'd1 : v - 16'd1;
  endfunction

  task automatic idle();
    wr_sel = 3'd0; rd_sel = 3'd0; abus_in = '0; mbus_in = '0;
    tx_hi_ld = 0; tx_lo_ld = 0; k_hi_ld = 0; k_lo_ld = 0; k_drive = 0;
    pc_cnt_n = 1; li_cnt_n = 1; sp_cnt_n = 1; si_cnt_n = 1; di_cnt_n = 1;
    sp_up = 1; si_up = 1; di_up = 1;
  endtask

  // One clock: predict, advance the model, check after the edge
  task automatic step(string tag);
    logic [15:0] e_ab, e_mb;
    logic        e_av, e_mv, e_cf;
    logic [15:0] n [8];
    e_ab = (rd_sel == 3'd0) ? 16'd0 : m[rd_sel];
    e_av = (rd_sel != 3'd0);
    e_mb = k_drive ? {8'd0, m[1][7:0]} : 16'd0;
    e_mv = k_drive;
    e_cf = (wr_sel == 3'd7) && (tx_hi_ld || tx_lo_ld);
    for (int i = 0; i < 8; i++) n[i] = m[i];
    n[2] = f_count(m[2], di_cnt_n, di_up);
    n[3] = f_count(m[3], si_cnt_n, si_up);
    n[4] = f_count(m[4], li_cnt_n, 1'b1);
    n[5] = f_count(m[5], sp_cnt_n, sp_up);
    n[6] = f_count(m[6], pc_cnt_n, 1'b1);
    if (tx_hi_ld) n[7][15:8] = mbus_in;
    if (tx_lo_ld) n[7][7:0]  = mbus_in;
    if (k_hi_ld)  n[1][15:8] = mbus_in;
    if (k_lo_ld)  n[1][7:0]  = mbus_in;
    if (wr_sel >= 3'd2) n[wr_sel] = abus_in;
    for (int i = 0; i < 8; i++) m[i] = n[i];
    @(posedge clk); #1;
    chk(tag, "abus_out", abus_out, e_ab);
    chk(tag, "abus_valid", {15'd0, abus_valid}, {15'd0, e_av});
    chk("R11", "mbus_out", {8'd0, mbus_out}, e_mb);
    chk("R11", "mbus_valid", {15'd0, mbus_valid}, {15'd0, e_mv});
    chk("R9", "tx_conflict", {15'd0, tx_conflict}, {15'd0, e_cf});
  endtask

  task automatic rd(logic [2:0] code, string tag);
    idle(); rd_sel = code; step(tag);
  endtask

  task automatic wr(logic [2:0] code, logic [15:0] v, string tag);
    idle(); wr_sel = code; abus_in = v; step(tag);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240613));
    for (int i = 0; i < 8; i++) m[i] = '0;
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state of outputs
    chk("R1", "abus_out", abus_out, 16'd0);
    chk("R1", "flags", {13'd0, abus_valid, mbus_valid, tx_conflict}, 16'd0);
    chk("R1", "mbus_out", {8'd0, mbus_out}, 16'd0);
    for (int c = 1; c < 8; c++) rd(3'(c), "R1");

    // R2/R3: distinct value per register, then read back
    for (int c = 2; c < 8; c++) wr(3'(c), 16'h1100 * 16'(c) + 16'h0033, "R2");
    wr(3'd1, 16'hDEAD, "R2");
    wr(3'd0, 16'hBEEF, "R2");
    for (int c = 1; c < 8; c++) rd(3'(c), "R3");
    rd(3'd0, "R4");

    // R5: pc wraps at top, li counts up
    wr(3'd6, 16'hFFFF, "R5");
    idle(); pc_cnt_n = 0; li_cnt_n = 0; step("R5");
    rd(3'd6, "R5");
    rd(3'd4, "R5");

    // R6: sp wraps downward at zero, si down, di up
    wr(3'd5, 16'h0000, "R6");
    idle(); sp_cnt_n = 0; sp_up = 0; si_cnt_n = 0; si_up = 0; di_cnt_n = 0; di_up = 1; step("R6");
    rd(3'd5, "R6"); rd(3'd3, "R6"); rd(3'd2, "R6");

    // R7: load wins over count in the same cycle
    idle(); wr_sel = 3'd5; abus_in = 16'h4242; sp_cnt_n = 0; sp_up = 0; step("R7");
    rd(3'd5, "R7");

    // R8: byte loads of the transfer register
    idle(); tx_hi_ld = 1; mbus_in = 8'hA5; step("R8");
    idle(); tx_lo_ld = 1; mbus_in = 8'h3C; step("R8");
    rd(3'd7, "R8");

    // R9: collision, full load wins, flag raised
    idle(); wr_sel = 3'd7; abus_in = 16'h1234; tx_lo_ld = 1; mbus_in = 8'hFF; step("R9");
    rd(3'd7, "R9");

    // R10/R11: constant bytes, read and drive
    idle(); k_hi_ld = 1; k_lo_ld = 1; mbus_in = 8'h5A; step("R10");
    idle(); k_lo_ld = 1; mbus_in = 8'hC3; step("R10");
    rd(3'd1, "R10");
    idle(); k_drive = 1; step("R11");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      idle();
      r = $urandom;
      wr_sel = r[2:0]; rd_sel = r[5:3];
      abus_in = $urandom; mbus_in = $urandom;
      tx_hi_ld = (r[9:7] == 0); tx_lo_ld = (r[12:10] == 0);
      k_hi_ld = (r[15:13] == 0); k_lo_ld = (r[18:16] == 0);
      k_drive = r[19];
      pc_cnt_n = r[20] | r[21]; li_cnt_n = r[22] | r[23];
      sp_cnt_n = r[24] | r[25]; si_cnt_n = r[26] | r[27];
      di_cnt_n = r[28] | r[29];
      sp_up = r[30]; si_up = r[31]; di_up = r[6];
      step(rd_sel == 3'd0 ? "R4" : "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule